// File: doc/BRIEF.md
# Multi-mode gated 16-bit timer

This block is a 16-bit up-counter compared against a 16-bit period register. When the two are equal on a count clock, the count returns to zero and a sticky interrupt flag is raised. The count clock can come from one of two places. The first is the system clock, which stands in for the instruction-cycle clock; in this case counting can be limited to the time a gate input is high. The second is the rising edges of an external clock pin, passed through a two-flop synchronizer or taken directly. A 2-bit prescale field divides the count clock by 1, 8, 64 or 256 before it reaches the counter.

Software programs a control register, a count register and a period register through write strobes, and reads all three back. Three control bits select the mode:
- Source bit clear and gate bit clear: plain timer.
- Source bit clear and gate bit set: gated timer. Here a falling gate edge, not a period match, raises the flag.
- Source bit set: the block counts external-clock edges and the gate bit has no effect. The sync bit then selects the synchronized or direct path.

Top module: `gtimer16`

## Requirements
- R1: After synchronous reset the control, count and period registers read zero and the interrupt flag is low.
- R2: With control bit 7 (run) set, bit 1 (source) clear, bit 6 (gate) clear and prescale bits 5:4 = 00, the count rises by one on every system clock cycle.
- R3: On a count clock with the count equal to the period, the count becomes zero and the flag is set. A period of zero keeps the count at zero and sets the flag on every count clock.
- R4: Prescale bits 5:4 set the division: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256. A count write or a clear run bit resets the prescaler.
- R5: With bit 1 clear and bit 6 set, the count advances only while the two-flop-synchronized gate is high. A falling gate edge sets the flag, and a period match clears the count without setting the flag.
- R6: With bit 1 set, the count advances on rising edges of the external clock, and bit 6 has no effect.
- R7: With bit 1 set, bit 2 (sync) set routes the external clock through two flops, adding two cycles of latency. With bit 2 clear, an edge counts at the first system clock edge that sees it.
- R8: The flag stays set until flag_clr is high, and a set event in the same cycle wins over the clear.
- R9: A count write takes effect on the next count clock, in place of that clock's increment. A period write takes effect at once.
- R10: While the run bit is clear the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| ctl_we | input | 1 | control register write strobe |
| ctl_wdata | input | 8 | control write data |
| cnt_we | input | 1 | count register write strobe |
| cnt_wdata | input | 16 | count write data |
| per_we | input | 1 | period register write strobe |
| per_wdata | input | 16 | period write data |
| flag_clr | input | 1 | clears the interrupt flag |
| ext_clk_i | input | 1 | external count clock |
| gate_i | input | 1 | gate input |
| ctl_o | output | 8 | control register readback |
| cnt_o | output | 16 | count register readback |
| per_o | output | 16 | period register readback |
| irq_o | output | 1 | sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a two-stage synchronizer and an 8-bit prescaler. With these values all four divide ratios, including divide-by-256, can be reached within a few hundred cycles. Small period values and preloaded counts reach the wrap and the period-zero case without waiting through 65,536 counts. The external clock runs at one eighth of the system rate, so the two-cycle synchronizer latency can be told apart from the direct path one edge at a time.

// File: rtl/gtimer16_pkg.sv
package gtimer16_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        MODE_TIMER,
        MODE_GATED,
        MODE_SYNC_CNT,
        MODE_ASYNC_CNT
    } mode_e;

    // run(7) gate(6) prescale(5:4) spare(3) sync(2) source(1) spare(0)
    typedef struct packed {
        logic       run;
        logic       gate;
        logic [1:0] ps;
        logic       spare3;
        logic       sync;
        logic       src;
        logic       spare0;
    } ctl_t;

    function automatic mode_e decode_mode(input logic src, input logic gate, input logic sync);
        mode_e m;
        if (!src) m = gate ? MODE_GATED : MODE_TIMER;
        else      m = sync ? MODE_SYNC_CNT : MODE_ASYNC_CNT;
        return m;
    endfunction

    function automatic int unsigned ps_shift(input logic [1:0] ps);
        int unsigned s;
        case (ps)
            2'b00:   s = 0;
            2'b01:   s = 3;
            2'b10:   s = 6;
            default: s = 8;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gtimer16_edge.sv
module gtimer16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    input  logic bypass_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= sig_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], sig_i};
            end
        end
    endgenerate

    assign lvl_o = bypass_i ? sig_i : sh_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_o;
    end

    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/gtimer16_prescale.sv
module gtimer16_prescale
    import gtimer16_pkg::*;
#(
    parameter int MAX_LOG = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       raw_i,
    input  logic [1:0] ps_i,
    output logic       tick_o
);
    logic [MAX_LOG-1:0] pre_q;
    logic [MAX_LOG-1:0] limit;

    always_comb limit = MAX_LOG'((1 << ps_shift(ps_i)) - 1);

    // >= so that lowering the ratio mid-count cannot stall the prescaler
    assign tick_o = raw_i & (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr_i)  pre_q <= '0;
        else if (raw_i)    pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end

    a_r4_clear_prescaler: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (pre_q == '0));

    a_r4_wrap_on_tick: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !clr_i) |=> (pre_q == '0));

endmodule

// File: rtl/gtimer16_core.sv
module gtimer16_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         match_flag_en_i,
    input  logic         ext_set_i,
    input  logic         flag_clr_i,
    input  logic [W-1:0] per_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_o,
    output logic         flag_o
);
    logic [W-1:0] cnt_q, val_q;
    logic         pend_q, flag_q;
    logic         hit, match_set;

    assign hit       = (cnt_q == per_i);
    assign match_set = tick_i & ~pend_q & hit & match_flag_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            val_q  <= '0;
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (tick_i) begin
                if (pend_q) begin
                    cnt_q  <= val_q;
                    pend_q <= 1'b0;
                end else if (hit) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (wr_en_i) begin
                pend_q <= 1'b1;
                val_q  <= wr_data_i;
            end
            flag_q <= match_set | ext_set_i | (flag_q & ~flag_clr_i);
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !pend_q && !hit) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !pend_q && hit) |=> (cnt_q == '0));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr_i) |=> flag_q);

    a_r9_load_pending: assert property (@(posedge clk) disable iff (rst)
        (tick_i && pend_q) |=> (cnt_q == $past(val_q)));

endmodule

// File: rtl/gtimer16.sv
module gtimer16
    import gtimer16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PS_LOG      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             flag_clr,
    input  logic             ext_clk_i,
    input  logic             gate_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic             irq_o
);
    ctl_t             ctl_q;
    logic [CNT_W-1:0] per_q;
    mode_e            mode;
    logic             ext_rise, ext_lvl, ext_fall;
    logic             gate_lvl, gate_rise, gate_fall;
    logic             int_ok, raw_tick, tick, gate_set, match_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            per_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
            if (per_we) per_q <= per_wdata;
        end
    end

    assign mode = decode_mode(ctl_q.src, ctl_q.gate, ctl_q.sync);

    gtimer16_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst(rst), .sig_i(ext_clk_i), .bypass_i(mode == MODE_ASYNC_CNT),
        .lvl_o(ext_lvl), .rise_o(ext_rise), .fall_o(ext_fall)
    );

    gtimer16_edge #(.STAGES(SYNC_STAGES)) u_gate (
        .clk(clk), .rst(rst), .sig_i(gate_i), .bypass_i(1'b0),
        .lvl_o(gate_lvl), .rise_o(gate_rise), .fall_o(gate_fall)
    );

    always_comb begin
        case (mode)
            MODE_TIMER:  int_ok = 1'b1;
            MODE_GATED:  int_ok = gate_lvl;
            default:     int_ok = ext_rise;
        endcase
    end

    assign raw_tick = ctl_q.run & int_ok;
    assign gate_set = ctl_q.run & (mode == MODE_GATED) & gate_fall;
    assign match_en = (mode != MODE_GATED);

    gtimer16_prescale #(.MAX_LOG(PS_LOG)) u_pre (
        .clk(clk), .rst(rst), .clr_i(cnt_we | ~ctl_q.run),
        .raw_i(raw_tick), .ps_i(ctl_q.ps), .tick_o(tick)
    );

    gtimer16_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick_i(tick), .match_flag_en_i(match_en),
        .ext_set_i(gate_set), .flag_clr_i(flag_clr), .per_i(per_q),
        .wr_en_i(cnt_we), .wr_data_i(cnt_wdata), .cnt_o(cnt_o), .flag_o(irq_o)
    );

    assign ctl_o = ctl_q;
    assign per_o = per_q;

    a_r10_off_holds: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.run |=> $stable(cnt_o));

    a_r5_gate_fall_flag: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && !ctl_q.src && ctl_q.gate && !gate_lvl && $past(gate_lvl)) |=> irq_o);

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (cnt_o == '0 && !irq_o && ctl_o == '0));

endmodule

// File: tb/gtimer16_tb.sv
`timescale 1ns/1ps
module gtimer16_tb;
    logic        clk = 1'b0, rst = 1'b1;
    logic        ctl_we = 0, cnt_we = 0, per_we = 0, flag_clr = 0;
    logic [7:0]  ctl_wdata = 0;
    logic [15:0] cnt_wdata = 0, per_wdata = 0;
    logic        ext_clk_i = 0, gate_i = 0;
    logic [7:0]  ctl_o;
    logic [15:0] cnt_o, per_o;
    logic        irq_o;

    int checks = 0, failures = 0, cyc = 0;
    string cur_req = "R1";
    bit    cmp_en = 0;

    always #2 clk = ~clk;

    gtimer16 u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .per_we(per_we), .per_wdata(per_wdata),
        .flag_clr(flag_clr), .ext_clk_i(ext_clk_i), .gate_i(gate_i),
        .ctl_o(ctl_o), .cnt_o(cnt_o), .per_o(per_o), .irq_o(irq_o)
    );

    // behavioural reference
    int m_cnt, m_per, m_val, m_pre, m_ctl;
    bit m_pend, m_flag, m_g1, m_g2, m_gp, m_e1, m_e2, m_ep;

    function automatic int div_of(int ps);
        return (ps == 0) ? 1 : (ps == 1) ? 8 : (ps == 2) ? 64 : 256;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 0; m_val = 0; m_pre = 0; m_ctl = 0;
            m_pend = 0; m_flag = 0; m_g1 = 0; m_g2 = 0; m_gp = 0;
            m_e1 = 0; m_e2 = 0; m_ep = 0;
        end else begin
            bit on, src, gen, gsel, gfall, esel, erise, raw, tick, setf;
            on = m_ctl[7]; src = m_ctl[1]; gen = m_ctl[6];
            gsel = m_g2; gfall = m_gp && !gsel;
            esel = m_ctl[2] ? m_e2 : ext_clk_i;
            erise = esel && !m_ep;
            raw = on && (src ? erise : (!gen || gsel));
            tick = raw && (m_pre >= div_of((m_ctl >> 4) & 3) - 1);
            setf = 0;
            if (tick) begin
                if (m_pend) begin m_cnt = m_val; m_pend = 0; end
                else if (m_cnt == m_per) begin
                    m_cnt = 0;
                    if (src || !gen) setf = 1;
                end else m_cnt = (m_cnt + 1) & 16'hFFFF;
            end
            if (on && !src && gen && gfall) setf = 1;
            m_flag = setf || (m_flag && !flag_clr);
            if (cnt_we) begin m_pend = 1; m_val = cnt_wdata; end
            if (cnt_we || !on) m_pre = 0;
            else if (raw) m_pre = tick ? 0 : m_pre + 1;
            m_gp = gsel; m_g2 = m_g1; m_g1 = gate_i;
            m_ep = esel; m_e2 = m_e1; m_e1 = ext_clk_i;
            if (per_we) m_per = per_wdata;
            if (ctl_we) m_ctl = ctl_wdata;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            chk({cur_req, " model count"}, cnt_o, m_cnt);
            chk({cur_req, " model flag"}, irq_o, m_flag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog for all requirements actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_ctl(int v);
        ctl_we = 1; ctl_wdata = 8'(v); step(1); ctl_we = 0;
    endtask
    task automatic wr_cnt(int v);
        cnt_we = 1; cnt_wdata = 16'(v); step(1); cnt_we = 0;
    endtask
    task automatic wr_per(int v);
        per_we = 1; per_wdata = 16'(v); step(1); per_we = 0;
    endtask
    task automatic clr_pulse();
        flag_clr = 1; step(1); flag_clr = 0;
    endtask
    task automatic ext_pulse();
        ext_clk_i = 1; step(4); ext_clk_i = 0; step(4);
    endtask

    initial begin
        int a;
        step(3);
        rst = 0;
        step(1);
        cmp_en = 1;
        chk("R1 count", cnt_o, 0);
        chk("R1 flag", irq_o, 0);
        chk("R1 ctl", ctl_o, 0);
        chk("R1 period", per_o, 0);

        cur_req = "R2";
        wr_per(1000);
        chk("R9 period write immediate", per_o, 1000);
        wr_ctl(8'h80);
        step(2);
        a = cnt_o;
        step(10);
        chk("R2 ten cycles", cnt_o, a + 10);

        cur_req = "R3";
        wr_cnt(0);
        wr_per(5);
        step(20);
        chk("R3 match flag", irq_o, 1);
        chk("R3 bounded", cnt_o <= 5, 1);
        per_we = 1; per_wdata = 0; cnt_we = 1; cnt_wdata = 0;
        step(1);
        per_we = 0; cnt_we = 0;
        step(4);
        clr_pulse();
        step(2);
        chk("R3 period zero count", cnt_o, 0);
        chk("R3 period zero flag", irq_o, 1);

        cur_req = "R8";
        wr_ctl(8'h00);
        step(10);
        chk("R8 sticky", irq_o, 1);
        clr_pulse();
        chk("R8 cleared", irq_o, 0);

        cur_req = "R10";
        a = cnt_o;
        step(10);
        chk("R10 hold", cnt_o, a);
        chk("R10 no flag", irq_o, 0);

        cur_req = "R9";
        wr_per(1000);
        wr_ctl(8'h80);
        wr_cnt(16'h1234);
        step(1);
        chk("R9 write applied", cnt_o, 16'h1234);
        wr_ctl(8'hB0);
        wr_cnt(7);
        step(10);
        chk("R9 not yet applied", cnt_o != 7, 1);
        step(250);
        chk("R9 applied after div256 tick", cnt_o, 7);

        cur_req = "R4";
        wr_ctl(8'h90);
        wr_cnt(0);
        step(90);
        chk("R4 div8", cnt_o, 10);
        wr_ctl(8'hA0);
        wr_cnt(0);
        step(258);
        chk("R4 div64", cnt_o, 3);

        cur_req = "R5";
        wr_ctl(8'h00);
        clr_pulse();
        wr_cnt(0);
        wr_ctl(8'hC0);
        step(5);
        a = cnt_o;
        chk("R5 gate low holds", cnt_o, a);
        gate_i = 1;
        step(20);
        chk("R5 no flag while high", irq_o, 0);
        gate_i = 0;
        step(5);
        chk("R5 gated count", cnt_o, 19);
        chk("R5 falling edge flag", irq_o, 1);
        a = cnt_o;
        step(10);
        chk("R5 hold while low", cnt_o, a);
        clr_pulse();
        wr_per(3);
        gate_i = 1;
        step(20);
        gate_i = 0;
        step(1);
        chk("R5 match no flag", irq_o, 0);
        step(5);

        cur_req = "R6";
        wr_ctl(8'h00);
        clr_pulse();
        wr_per(1000);
        wr_cnt(0);
        wr_ctl(8'h86);
        for (int i = 0; i < 6; i++) ext_pulse();
        chk("R6 edges counted", cnt_o, 5);
        wr_ctl(8'hC6);
        for (int i = 0; i < 3; i++) ext_pulse();
        chk("R6 gate bit ignored", cnt_o, 8);

        cur_req = "R7";
        wr_ctl(8'h82);
        step(2);
        ext_clk_i = 1;
        step(1);
        chk("R7 direct path", cnt_o, 9);
        ext_clk_i = 0;
        step(3);
        wr_ctl(8'h86);
        step(2);
        ext_clk_i = 1;
        step(2);
        chk("R7 sync not yet", cnt_o, 9);
        step(1);
        chk("R7 sync two-cycle latency", cnt_o, 10);
        ext_clk_i = 0;
        step(4);

        cur_req = "R8";
        wr_ctl(8'h80);
        per_we = 1; per_wdata = 0; cnt_we = 1; cnt_wdata = 0;
        step(1);
        per_we = 0; cnt_we = 0;
        step(3);
        flag_clr = 1;
        step(3);
        chk("R8 set beats clear", irq_o, 1);
        flag_clr = 0;
        step(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule